// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block sequences the low-power state of a small processor core. When the decoded sleep strobe arrives and no enabled interrupt is pending, it stops the oscillator driver, stalls the core, pulses a watchdog clear and records in two status bits that a power-down really took place. If an enabled interrupt is already pending when the strobe arrives, the sleep request does nothing at all.

While the core is asleep, the block watches three wake causes in a fixed priority order: the external active-low reset pin (after a synchronizer), a watchdog time-out pulse and any interrupt source whose flag and enable bits are both set. The global interrupt enable plays no part in deciding whether to wake. It only decides whether, after the first instruction following sleep, the core is asked to branch to the interrupt vector. The oscillator comes back one cycle before the stall is released.

The status bits are `pd_bit` and `to_bit`. `pd_bit` shows whether a sleep actually ran. `to_bit` shows whether the last wake was caused by the watchdog. A clear-watchdog strobe sets both bits.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: With `rst` high at a clock edge, the block returns to the running state, and after that edge `osc_en`=1, `core_stall`=0, `pd_bit`=1, `to_bit`=1, and `wdt_clr`, `wake_pulse`, `vector_req` and `core_reset` are all 0.
- R2: A `sleep_stb` while running with no pending source puts the block to sleep on that clock edge. After the edge, `osc_en`=0, `core_stall`=1, `pd_bit`=0 and `to_bit`=1, and `wdt_clr` is high for exactly that one cycle.
- R3: A `sleep_stb` while running, when at least one bit i has `irq_flags[i]`=1 and `irq_enables[i]`=1, has no effect. The core keeps running, `pd_bit` and `to_bit` keep their values and `wdt_clr` stays 0.
- R4: A flag whose matching enable bit is 0 neither blocks sleep nor wakes the core.
- R5: While asleep, a pending source wakes the core whatever the value of `gie`. On the deciding edge, `osc_en` returns to 1, `wdt_clr` pulses and `core_stall` stays 1. On the next edge, `core_stall` falls and `wake_pulse` is high for one cycle.
- R6: If `gie` was 1 on the deciding edge of an interrupt wake, `vector_req` is high for one cycle, in the cycle right after `wake_pulse`. If `gie` was 0, `vector_req` stays 0.
- R7: A `wdt_timeout` while asleep wakes the core as in R5, clears `to_bit` and never raises `vector_req`. It takes priority over a pending interrupt on the same edge. While running, the timeout input has no effect.
- R8: An external reset seen while asleep restores `osc_en`, releases the stall one cycle later without `wake_pulse`, leaves `pd_bit` and `to_bit` unchanged and takes priority over a same-cycle watchdog timeout.
- R9: A `clrwdt_stb` while running, and without `sleep_stb` in the same cycle, sets `pd_bit` and `to_bit` to 1 and pulses `wdt_clr`. When `sleep_stb` is also high, the clear strobe is ignored.
- R10: `core_reset` follows the level of `ext_rst_n` in any state, inverted and delayed by `SYNC_STAGES`+1 clock edges.
- R11: An enabled interrupt that rises the cycle after a sleep strobe lets the sleep complete (`pd_bit`=0, watchdog cleared). The core then wakes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| sleep_stb | input | 1 | Decoded sleep instruction, one cycle |
| clrwdt_stb | input | 1 | Decoded clear-watchdog instruction, one cycle |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| irq_flags | input | NUM_SRC | Interrupt flag per source |
| irq_enables | input | NUM_SRC | Interrupt enable per source, bit i pairs with flag bit i |
| gie | input | 1 | Global interrupt enable |
| osc_en | output | 1 | Oscillator driver enable |
| wdt_clr | output | 1 | Watchdog counter clear pulse |
| core_stall | output | 1 | Holds the core pipeline |
| wake_pulse | output | 1 | One-cycle continuation-wake indication |
| vector_req | output | 1 | Request to branch to the interrupt vector |
| core_reset | output | 1 | Synchronized device reset from the pin |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |

## Verification
Wake causes can coincide on one edge while asleep, so the bench sets up these collisions directly. In one case a watchdog timeout and an enabled interrupt with `gie` set arrive together. This must yield a timeout wake with `to_bit` cleared and no vector request. In another case the synchronized pin reset lands on the same edge as a timeout, and `to_bit` must remain 1 with no `wake_pulse`. The bench also drives a clear-watchdog strobe together with a no-op sleep, and checks that the status bits and the watchdog clear stay untouched. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_DOZE   = 2'd1,
    PS_RESUME = 2'd2
  } pwr_state_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_PIN  = 2'd1,
    WK_WDT  = 2'd2,
    WK_IRQ  = 2'd3
  } wake_src_e;

  typedef struct packed {
    logic enter_sleep;
    logic clr_wdt;
    logic wdt_wake;
  } status_evt_t;

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic low_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= ~pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[LAST-1:0], ~pin_n};
      end
    end
  endgenerate

  assign low_o = stg[LAST];
endmodule

// File: rtl/pwr_wake_arb.sv
module pwr_wake_arb
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] irq_flags,
  input  logic [NUM_SRC-1:0] irq_enables,
  input  logic               ext_low,
  input  logic               wdt_timeout,
  output logic               pend,
  output wake_src_e          src
);
  logic [NUM_SRC-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = irq_flags[i] & irq_enables[i];
    end
  endgenerate

  assign pend = |hit;

  always_comb begin
    if (ext_low)          src = WK_PIN;
    else if (wdt_timeout) src = WK_WDT;
    else if (pend)        src = WK_IRQ;
    else                  src = WK_NONE;
  end
endmodule

// File: rtl/pwr_status_regs.sv
module pwr_status_regs
  import pwr_sleep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  status_evt_t evt,
  output logic        pd_bit,
  output logic        to_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_bit <= 1'b1;
      to_bit <= 1'b1;
    end else if (evt.enter_sleep) begin
      pd_bit <= 1'b0;
      to_bit <= 1'b1;
    end else if (evt.clr_wdt) begin
      pd_bit <= 1'b1;
      to_bit <= 1'b1;
    end else if (evt.wdt_wake) begin
      to_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
  import pwr_sleep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sleep_stb,
  input  logic        clrwdt_stb,
  input  logic        gie,
  input  logic        pend,
  input  logic        ext_low,
  input  wake_src_e   src,
  output status_evt_t evt,
  output logic        osc_en,
  output logic        wdt_clr,
  output logic        core_stall,
  output logic        wake_pulse,
  output logic        vector_req,
  output logic        core_reset
);
  pwr_state_e state;
  logic       vec_arm;
  logic       cont_q;
  logic       vec_pend_q;

  always_comb begin
    evt.enter_sleep = (state == PS_RUN) && sleep_stb && !pend;
    evt.clr_wdt     = (state == PS_RUN) && !sleep_stb && clrwdt_stb;
    evt.wdt_wake    = (state == PS_DOZE) && (src == WK_WDT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_RUN;
      osc_en     <= 1'b1;
      core_stall <= 1'b0;
      wdt_clr    <= 1'b0;
      wake_pulse <= 1'b0;
      vector_req <= 1'b0;
      core_reset <= 1'b0;
      vec_arm    <= 1'b0;
      cont_q     <= 1'b0;
      vec_pend_q <= 1'b0;
    end else begin
      wdt_clr    <= 1'b0;
      wake_pulse <= 1'b0;
      vector_req <= 1'b0;
      core_reset <= ext_low;
      case (state)
        PS_RUN: begin
          vector_req <= vec_arm;
          vec_arm    <= 1'b0;
          if (sleep_stb) begin
            if (!pend) begin
              state      <= PS_DOZE;
              osc_en     <= 1'b0;
              core_stall <= 1'b1;
              wdt_clr    <= 1'b1;
            end
          end else if (clrwdt_stb) begin
            wdt_clr <= 1'b1;
          end
        end
        PS_DOZE: begin
          case (src)
            WK_PIN: begin
              state      <= PS_RESUME;
              osc_en     <= 1'b1;
              cont_q     <= 1'b0;
              vec_pend_q <= 1'b0;
            end
            WK_WDT: begin
              state      <= PS_RESUME;
              osc_en     <= 1'b1;
              wdt_clr    <= 1'b1;
              cont_q     <= 1'b1;
              vec_pend_q <= 1'b0;
            end
            WK_IRQ: begin
              state      <= PS_RESUME;
              osc_en     <= 1'b1;
              wdt_clr    <= 1'b1;
              cont_q     <= 1'b1;
              vec_pend_q <= gie;
            end
            default: ;
          endcase
        end
        PS_RESUME: begin
          state      <= PS_RUN;
          core_stall <= 1'b0;
          wake_pulse <= cont_q;
          vec_arm    <= cont_q & vec_pend_q;
        end
        default: state <= PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_rst_n,
  input  logic               sleep_stb,
  input  logic               clrwdt_stb,
  input  logic               wdt_timeout,
  input  logic [NUM_SRC-1:0] irq_flags,
  input  logic [NUM_SRC-1:0] irq_enables,
  input  logic               gie,
  output logic               osc_en,
  output logic               wdt_clr,
  output logic               core_stall,
  output logic               wake_pulse,
  output logic               vector_req,
  output logic               core_reset,
  output logic               pd_bit,
  output logic               to_bit
);
  logic        ext_low;
  logic        pend;
  wake_src_e   src;
  status_evt_t evt;

  pwr_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (ext_rst_n),
    .low_o (ext_low)
  );

  pwr_wake_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .irq_flags   (irq_flags),
    .irq_enables (irq_enables),
    .ext_low     (ext_low),
    .wdt_timeout (wdt_timeout),
    .pend        (pend),
    .src         (src)
  );

  pwr_sleep_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .sleep_stb  (sleep_stb),
    .clrwdt_stb (clrwdt_stb),
    .gie        (gie),
    .pend       (pend),
    .ext_low    (ext_low),
    .src        (src),
    .evt        (evt),
    .osc_en     (osc_en),
    .wdt_clr    (wdt_clr),
    .core_stall (core_stall),
    .wake_pulse (wake_pulse),
    .vector_req (vector_req),
    .core_reset (core_reset)
  );

  pwr_status_regs u_status (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .pd_bit (pd_bit),
    .to_bit (to_bit)
  );
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ext_rst_n,
  input logic               sleep_stb,
  input logic               clrwdt_stb,
  input logic               wdt_timeout,
  input logic [NUM_SRC-1:0] irq_flags,
  input logic [NUM_SRC-1:0] irq_enables,
  input logic               gie,
  input logic               osc_en,
  input logic               wdt_clr,
  input logic               core_stall,
  input logic               wake_pulse,
  input logic               vector_req,
  input logic               core_reset,
  input logic               pd_bit,
  input logic               to_bit
);
  logic any_pend;
  assign any_pend = |(irq_flags & irq_enables);

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!core_stall && sleep_stb && !any_pend) |=> (!osc_en && core_stall && wdt_clr && !pd_bit && to_bit)); // R2

  AST_PD_ONLY_BY_SLEEP: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_bit) |-> $past(sleep_stb)); // R2

  AST_NOOP_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (!core_stall && sleep_stb && any_pend) |=> ($stable(pd_bit) && $stable(to_bit) && !wdt_clr && !core_stall)); // R3

  AST_OSC_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_stall) |-> ($past(osc_en) && osc_en)); // R5

  AST_WAKE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> $fell(core_stall)); // R5

  AST_VECTOR_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
    vector_req |-> $past(wake_pulse)); // R6

  AST_TO_BY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    $fell(to_bit) |-> ($past(wdt_timeout) && $past(core_stall))); // R7
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/pwr_sleep_ctrl_tb_top.sv
module pwr_sleep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 8;
  localparam int SYNC       = 2;
  localparam int WD_CYCLES  = 5000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ext_rst_n = 1'b1;
  logic            sleep_stb = 1'b0;
  logic            clrwdt_stb = 1'b0;
  logic            wdt_timeout = 1'b0;
  logic [NSRC-1:0] irq_flags = '0;
  logic [NSRC-1:0] irq_enables = '0;
  logic            gie = 1'b0;
  logic osc_en, wdt_clr, core_stall, wake_pulse, vector_req, core_reset, pd_bit, to_bit;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    cmp_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl #(.NUM_SRC(NSRC), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .sleep_stb(sleep_stb),
    .clrwdt_stb(clrwdt_stb), .wdt_timeout(wdt_timeout), .irq_flags(irq_flags),
    .irq_enables(irq_enables), .gie(gie), .osc_en(osc_en), .wdt_clr(wdt_clr),
    .core_stall(core_stall), .wake_pulse(wake_pulse), .vector_req(vector_req),
    .core_reset(core_reset), .pd_bit(pd_bit), .to_bit(to_bit));

  // Behavioural reference: mode 0 running, 1 asleep, 2 resuming
  int m_mode;
  bit m_osc, m_stall, m_wclr, m_wake, m_vec, m_varm, m_cont, m_vgo, m_crst, m_pd, m_to;
  bit pin_hist[$];

  always @(posedge clk) begin
    bit seen_low, any;
    any = (irq_flags & irq_enables) != '0;
    if (rst) begin
      m_mode = 0; m_osc = 1; m_stall = 0; m_wclr = 0; m_wake = 0; m_vec = 0;
      m_varm = 0; m_cont = 0; m_vgo = 0; m_crst = 0; m_pd = 1; m_to = 1;
      pin_hist = {};
      repeat (SYNC) pin_hist.push_back(1'b0);
      cmp_en = 1'b1;
    end else begin
      seen_low = pin_hist[$];
      void'(pin_hist.pop_back());
      pin_hist.push_front(!ext_rst_n);
      m_wclr = 0; m_wake = 0; m_vec = 0; m_crst = seen_low;
      if (m_mode == 0) begin
        m_vec = m_varm; m_varm = 0;
        if (sleep_stb && !any) begin
          m_mode = 1; m_osc = 0; m_stall = 1; m_wclr = 1; m_pd = 0; m_to = 1;
        end else if (!sleep_stb && clrwdt_stb) begin
          m_wclr = 1; m_pd = 1; m_to = 1;
        end
      end else if (m_mode == 1) begin
        if (seen_low) begin
          m_mode = 2; m_osc = 1; m_cont = 0; m_vgo = 0;
        end else if (wdt_timeout) begin
          m_mode = 2; m_osc = 1; m_wclr = 1; m_cont = 1; m_vgo = 0; m_to = 0;
        end else if (any) begin
          m_mode = 2; m_osc = 1; m_wclr = 1; m_cont = 1; m_vgo = gie;
        end
      end else begin
        m_mode = 0; m_stall = 0; m_wake = m_cont; m_varm = m_cont & m_vgo;
      end
    end
  end

  task automatic cmp1(string nm, logic act, bit exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s model %s actual=%b expected=%b t=%0t", cur_req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      checks++;
      cmp1("osc_en", osc_en, m_osc);
      cmp1("wdt_clr", wdt_clr, m_wclr);
      cmp1("core_stall", core_stall, m_stall);
      cmp1("wake_pulse", wake_pulse, m_wake);
      cmp1("vector_req", vector_req, m_vec);
      cmp1("core_reset", core_reset, m_crst);
      cmp1("pd_bit", pd_bit, m_pd);
      cmp1("to_bit", to_bit, m_to);
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    // R1 reset state
    cur_req = "R1";
    chk("R1", "osc_en", osc_en, 1'b1);
    chk("R1", "core_stall", core_stall, 1'b0);
    chk("R1", "pd_bit", pd_bit, 1'b1);
    chk("R1", "to_bit", to_bit, 1'b1);
    chk("R1", "core_reset", core_reset, 1'b0);

    // R2 plain sleep entry
    cur_req = "R2";
    irq_enables = 8'b0000_0011;
    sleep_stb = 1'b1; step(); sleep_stb = 1'b0;
    chk("R2", "osc_en", osc_en, 1'b0);
    chk("R2", "core_stall", core_stall, 1'b1);
    chk("R2", "wdt_clr", wdt_clr, 1'b1);
    chk("R2", "pd_bit", pd_bit, 1'b0);
    step();
    chk("R2", "wdt_clr one cycle", wdt_clr, 1'b0);

    // R5 interrupt wake with gie clear
    cur_req = "R5";
    irq_flags = 8'b0000_0001; step(); irq_flags = '0;
    chk("R5", "osc_en back", osc_en, 1'b1);
    chk("R5", "stall held", core_stall, 1'b1);
    chk("R5", "wdt_clr", wdt_clr, 1'b1);
    step();
    chk("R5", "stall released", core_stall, 1'b0);
    chk("R5", "wake_pulse", wake_pulse, 1'b1);
    step();
    chk("R6", "no vector gie=0", vector_req, 1'b0);

    // R6 interrupt wake with gie set
    cur_req = "R6";
    sleep_stb = 1'b1; step(); sleep_stb = 1'b0;
    gie = 1'b1; irq_flags = 8'b0000_0010; step(); irq_flags = '0;
    step();
    chk("R6", "wake_pulse", wake_pulse, 1'b1);
    chk("R6", "vector not yet", vector_req, 1'b0);
    step();
    chk("R6", "vector_req", vector_req, 1'b1);
    step();
    chk("R6", "vector one cycle", vector_req, 1'b0);
    gie = 1'b0;

    // R3 and R9: no-op sleep with a clear strobe in the same cycle
    cur_req = "R3";
    irq_flags = 8'b0000_0001;
    sleep_stb = 1'b1; clrwdt_stb = 1'b1; step(); sleep_stb = 1'b0; clrwdt_stb = 1'b0;
    chk("R3", "core_stall", core_stall, 1'b0);
    chk("R3", "pd_bit kept", pd_bit, 1'b0);
    chk("R9", "clear ignored wdt_clr", wdt_clr, 1'b0);
    irq_flags = '0;

    // R9 clear-watchdog strobe
    cur_req = "R9";
    clrwdt_stb = 1'b1; step(); clrwdt_stb = 1'b0;
    chk("R9", "pd_bit", pd_bit, 1'b1);
    chk("R9", "to_bit", to_bit, 1'b1);
    chk("R9", "wdt_clr", wdt_clr, 1'b1);

    // R4 flag without enable
    cur_req = "R4";
    irq_flags = 8'b0000_0100;
    sleep_stb = 1'b1; step(); sleep_stb = 1'b0;
    chk("R4", "sleep not blocked", core_stall, 1'b1);
    step(3);
    chk("R4", "still asleep", osc_en, 1'b0);
    irq_flags = '0;

    // R7 timeout colliding with an interrupt, gie set
    cur_req = "R7";
    gie = 1'b1; irq_flags = 8'b0000_0001; wdt_timeout = 1'b1; step();
    wdt_timeout = 1'b0; irq_flags = '0;
    chk("R7", "to_bit cleared", to_bit, 1'b0);
    chk("R7", "osc_en", osc_en, 1'b1);
    step();
    chk("R7", "wake_pulse", wake_pulse, 1'b1);
    step();
    chk("R7", "no vector", vector_req, 1'b0);
    gie = 1'b0;
    wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
    chk("R7", "timeout while running", core_stall, 1'b0);
    chk("R7", "to_bit while running", to_bit, 1'b0);

    // R11 interrupt rises just after the sleep strobe
    cur_req = "R11";
    sleep_stb = 1'b1; step(); sleep_stb = 1'b0;
    chk("R11", "pd_bit", pd_bit, 1'b0);
    chk("R11", "to_bit set by sleep", to_bit, 1'b1);
    irq_flags = 8'b0000_0010; step(); irq_flags = '0;
    chk("R11", "osc_en", osc_en, 1'b1);
    step();
    chk("R11", "wake_pulse", wake_pulse, 1'b1);

    // R8 pin reset while asleep colliding with a timeout
    cur_req = "R8";
    sleep_stb = 1'b1; step(); sleep_stb = 1'b0;
    ext_rst_n = 1'b0; step(2);
    wdt_timeout = 1'b1; step(); wdt_timeout = 1'b0;
    chk("R8", "core_reset", core_reset, 1'b1);
    chk("R8", "osc_en", osc_en, 1'b1);
    chk("R8", "to_bit kept", to_bit, 1'b1);
    chk("R8", "wdt_clr", wdt_clr, 1'b0);
    step();
    chk("R8", "stall released", core_stall, 1'b0);
    chk("R8", "no wake_pulse", wake_pulse, 1'b0);
    chk("R8", "pd_bit kept", pd_bit, 1'b0);
    ext_rst_n = 1'b1; step(SYNC + 1);

    // R10 pin reset while running
    cur_req = "R10";
    chk("R10", "core_reset released", core_reset, 1'b0);
    ext_rst_n = 1'b0; step(SYNC);
    chk("R10", "before latency", core_reset, 1'b0);
    step();
    chk("R10", "after latency", core_reset, 1'b1);
    chk("R10", "still running", core_stall, 1'b0);
    ext_rst_n = 1'b1; step(SYNC + 1);
    chk("R10", "released", core_reset, 1'b0);

    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule